// File: doc/BRIEF.md
# Byte-Serial Pointer Register Loader

This block gives a host with an 8-bit control port access to values wider than one byte through a single byte-wide data register. The host first writes a pointer-clear strobe, which sets an internal byte index to zero. Every later access to the data register moves exactly one byte and steps the index forward. Writes build a 28-bit mailbox address, and reads return a fixed 32-bit revision word. Both run most significant byte first.

After four accesses the index stops at its end value. The data register then ignores accesses until the pointer is cleared again. The top bits of the first written byte fall outside the 28-bit address space and are dropped. A done flag shows that a full four-byte address load has completed.

Top module: `byte_ptr_loader`

## Requirements
- R1: After reset the byte index is zero, `mbox_addr` is 0, `load_done` is 0, and `rev_byte` shows bits 31:24 of the revision word.
- R2: A cycle with `ptr_clr` high sets the index to zero and clears `load_done` at the next edge. It takes priority over any write or read in the same cycle, and that access has no effect.
- R3: A write accepted at index k (0..3) stores `wr_byte` into `mbox_addr` bits [31-8k : 24-8k] clipped to 28 bits. At k=0 only `wr_byte[3:0]` is kept, as `mbox_addr[27:24]`.
- R4: While the index k is below 4, `rev_byte` shows revision word bits [31-8k : 24-8k]. An accepted read advances the index by one.
- R5: Once the index reaches 4 it stays there, and `rev_byte` reads 0. Until the next clear, further writes leave `mbox_addr` unchanged and further reads leave the index unchanged.
- R6: `load_done` rises at the edge that accepts a write at index 3. It stays high until the next pointer clear.
- R7: When `wr_en` and `rd_en` are both high in one cycle, only the write is accepted, and the index advances by one.
- R8: In a cycle with no accepted write, `mbox_addr` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_clr | input | 1 | Pointer clear strobe |
| wr_en | input | 1 | Write access to the data register |
| rd_en | input | 1 | Read access to the data register |
| wr_byte | input | 8 | Byte written |
| rev_byte | output | 8 | Revision byte at the current index |
| mbox_addr | output | 28 | Assembled mailbox address |
| load_done | output | 1 | Four-byte address load complete |

## Verification
The main pattern is a full four-byte address load using a first byte whose high nibble is set. This shows whether the 28-bit clipping and the byte order are right. A four-read pass after a clear checks the most-significant-first revision order. Extra accesses past the fourth separate a saturating index from one that wraps. A mixed read-then-write sequence, same-cycle read and write, and a clear arriving with an access show whether reads and writes share one index, which access wins, and whether clear takes priority. Idle cycles between accesses confirm that nothing advances without a strobe.

// File: rtl/byte_ptr_loader.sv
module byte_ptr_loader #(
  parameter int          ADDR_W  = 28,
  parameter int          NBYTES  = 4,
  parameter logic [31:0] REV_WORD = 32'hA5C3_1E07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wr_byte,
  output logic [7:0]        rev_byte,
  output logic [ADDR_W-1:0] mbox_addr,
  output logic              load_done
);
  localparam int IDX_W  = $clog2(NBYTES + 1);
  localparam int FULL_W = 8 * NBYTES;

  logic [IDX_W-1:0]  idx;
  logic [FULL_W-1:0] addr_full;
  logic              room;
  logic              wr_ok;
  logic              rd_ok;
  logic [IDX_W-1:0]  shift_bytes;

  assign room        = idx < IDX_W'(NBYTES);
  assign wr_ok       = !ptr_clr && wr_en && room;
  assign rd_ok       = !ptr_clr && !wr_en && rd_en && room;
  assign shift_bytes = IDX_W'(NBYTES - 1) - idx;
  assign rev_byte    = room ? 8'(REV_WORD >> (8 * shift_bytes)) : 8'h00;
  assign mbox_addr   = addr_full[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      addr_full <= '0;
      load_done <= 1'b0;
    end else if (ptr_clr) begin
      idx       <= '0;
      load_done <= 1'b0;
    end else if (wr_ok) begin
      addr_full <= (addr_full & ~(FULL_W'(8'hFF) << (8 * shift_bytes)))
                 | ((FULL_W'(wr_byte) << (8 * shift_bytes)) & FULL_W'({ADDR_W{1'b1}}));
      idx       <= idx + 1'b1;
      if (idx == IDX_W'(NBYTES - 1)) load_done <= 1'b1;
    end else if (rd_ok) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

module byte_ptr_loader_chk #(
  parameter int          ADDR_W   = 28,
  parameter logic [31:0] REV_WORD = 32'hA5C3_1E07
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ptr_clr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rev_byte,
  input logic [ADDR_W-1:0] mbox_addr,
  input logic              load_done
);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> (rev_byte == REV_WORD[31:24]) && !load_done);
  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || ptr_clr) |=> $stable(mbox_addr));
  p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(wr_en && !ptr_clr));
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !ptr_clr) |=> load_done);
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !ptr_clr) |=> $stable(rev_byte));
endmodule

bind byte_ptr_loader byte_ptr_loader_chk #(.ADDR_W(ADDR_W), .REV_WORD(REV_WORD)) u_chk (
  .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .wr_en(wr_en), .rd_en(rd_en),
  .rev_byte(rev_byte), .mbox_addr(mbox_addr), .load_done(load_done)
);

// File: tb/test_byte_ptr_loader.sv
`timescale 1ns/1ps
module test_byte_ptr_loader;
  localparam logic [31:0] REV = 32'hA5C3_1E07;

  logic clk = 0;
  logic rst_n = 0;
  logic ptr_clr = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wr_byte = 0;
  logic [7:0] rev_byte;
  logic [27:0] mbox_addr;
  logic load_done;

  int checks = 0, fails = 0;
  int m_idx = 0;
  logic [27:0] m_addr = 0;
  logic m_done = 0;

  always #2.5 clk = ~clk;

  byte_ptr_loader #(.REV_WORD(REV)) i_byte_ptr_loader (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_byte(wr_byte), .rev_byte(rev_byte), .mbox_addr(mbox_addr), .load_done(load_done)
  );

  function automatic logic [7:0] exp_rev(int k);
    if (k < 4) return REV[31 - 8*k -: 8];
    return 8'h00;
  endfunction

  task automatic compare(string req);
    logic [7:0] er;
    er = exp_rev(m_idx);
    checks++;
    if (rev_byte !== er || mbox_addr !== m_addr || load_done !== m_done) begin
      fails++;
      $display("FAIL %s: rev=%h addr=%h done=%b expected rev=%h addr=%h done=%b",
               req, rev_byte, mbox_addr, load_done, er, m_addr, m_done);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic r, input logic [7:0] d, input string req);
    @(negedge clk);
    ptr_clr = c; wr_en = w; rd_en = r; wr_byte = d;
    @(posedge clk);
    if (c) begin
      m_idx = 0; m_done = 0;
    end else if (w && m_idx < 4) begin
      logic [31:0] full;
      full = {4'h0, m_addr};
      full[31 - 8*m_idx -: 8] = d;
      m_addr = full[27:0];
      if (m_idx == 3) m_done = 1;
      m_idx++;
    end else if (r && m_idx < 4) begin
      m_idx++;
    end
    #1;
    compare(req);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: timeout actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compare("R1 reset state");
    @(negedge clk); rst_n = 1;
    step(0,0,0,8'h00,"R1 idle after reset");
    step(1,0,0,8'h00,"R2 clear");
    step(0,1,0,8'hF3,"R3 first byte masked");
    step(0,0,0,8'h00,"R8 idle hold");
    step(0,1,0,8'h45,"R3 byte1");
    step(0,1,0,8'h67,"R3 byte2");
    step(0,1,0,8'h89,"R6 fourth write sets done");
    step(0,1,0,8'hEE,"R5 extra write ignored");
    step(0,0,1,8'h00,"R5 extra read ignored");
    step(0,0,0,8'h00,"R6 done holds");
    step(1,0,0,8'h00,"R2 clear drops done");
    for (int i = 0; i < 4; i++) step(0,0,1,8'h00,"R4 revision read");
    step(0,0,1,8'h00,"R5 read saturated");
    step(1,1,0,8'hAA,"R2 clear beats write");
    step(0,1,1,8'h12,"R7 write wins over read");
    step(0,0,1,8'h00,"R4 read after write");
    step(0,1,0,8'h34,"R3 write at index 2");
    step(0,1,0,8'h56,"R6 write at index 3");
    step(1,0,1,8'h00,"R2 clear beats read");
    step(0,0,0,8'h00,"R8 addr kept after clear");
    for (int i = 0; i < 4; i++) step(0,1,0,8'(8'h0C + i),"R3 reload");
    step(0,0,0,8'h00,"R6 reload done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule